// File: doc/BRIEF.md
# Slow Tick Source Selector

This block produces the slow timekeeping tick for an always-on timer domain. The tick comes from one of two strobes: an external low-frequency oscillator, or an internal RC oscillator that is first divided by a fixed stage and then by a programmable stage. Software controls the block through a 32-bit write port. A combinational read port returns the register contents. Both tick sources arrive as single-cycle enable strobes in the system clock domain.

A change of source is held back until the source still in use emits a tick. This keeps the tick stream free of cut or doubled ticks. The external source can die while it is in use. If the bypass bit is clear, a watchdog then counts internal strobes and, at a timeout, falls back to the internal source. Writes to the control register must carry an unlock key. A gated copy of the tick drives an output pin.

Top module: `slow_tick_sel`

## Requirements
- R1: A write to address 0x00 changes the control register only when data bits [31:16] equal 0x16AA. Any other value in those bits leaves every control bit unchanged.
- R2: A read of address 0x00 returns the source select in bit 0, the external-oscillator enable in bit 4 and the fallback bypass in bit 15. All other bits, including [31:16], read as zero. `ext_osc_en_o` follows bit 4.
- R3: With the internal source in use, `tick_o` pulses once every FIX_DIV*(N+1) internal strobes. N is the field at address 0x08, bits [4:0], and it reads back at that address.
- R4: With the external source in use, each external strobe appears on `tick_o` one clock later.
- R5: After the select bit changes, `tick_o` keeps following the old source up to and including that source's next tick. The new source takes over from the following cycle, and `src_ext_o` (1 = external) reports the source in use.
- R6: With bit 15 clear and the external source in use, TIMEOUT internal strobes without an external strobe switch the source to internal and clear control bit 0. Bit 4 is left unchanged.
- R7: With bit 15 set, the external source stays in use however long it stays silent.
- R8: `tick_pin_o` equals `tick_o` while bit 0 at address 0x60 is set, and is 0 otherwise. That bit reads back at 0x60.
- R9: After reset, all registers read zero, the internal source is in use, and both tick outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 32 | Read data, combinational |
| int_tick_i | input | 1 | Internal RC oscillator strobe |
| ext_tick_i | input | 1 | External oscillator strobe |
| tick_o | output | 1 | Selected slow tick |
| tick_pin_o | output | 1 | Gated tick for the output pin |
| src_ext_o | output | 1 | Source in use, 1 = external |
| ext_osc_en_o | output | 1 | External oscillator enable |

## Verification
A stuck fixed or programmable divider count appears on `tick_o` within one internal period of FIX_DIV*(N+1) strobes, as a pulse that is misplaced or missing. A source register that commits early or late moves one tick by a cycle, or duplicates or drops it, at the first switch. A watchdog counter that is off by one moves the fallback edge on `src_ext_o` by one strobe. A key check that is too lenient shows up on the next read of address 0x00. The bench compares every output on every cycle against its own model, so each of these faults shows up in the cycle where it first appears.

// File: rtl/slow_tick_pkg.sv
package slow_tick_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_PRE  = 8'h08;
  localparam logic [ADDR_W-1:0] A_GATE = 8'h60;
  localparam logic [15:0] UNLOCK_KEY = 16'h16AA;
  localparam int unsigned B_SEL = 0;
  localparam int unsigned B_EXT_EN = 4;
  localparam int unsigned B_BYPASS = 15;

  typedef struct packed {
    logic bypass;
    logic ext_en;
    logic sel;
  } ctrl_t;
endpackage

// File: rtl/slow_tick_regs.sv
module slow_tick_regs
  import slow_tick_pkg::*;
#(
  parameter int unsigned PRE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic              fail_i,
  output ctrl_t             ctrl_o,
  output logic [PRE_W-1:0]  pre_n_o,
  output logic              gate_o
);
  ctrl_t            ctrl_q;
  logic [PRE_W-1:0] pre_q;
  logic             gate_q;
  logic             wr_ctrl, key_ok;
  logic             unused_wr;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == A_CTRL);
  assign key_ok    = (wr_data_i[31:16] == UNLOCK_KEY);
  assign unused_wr = ^wr_data_i[14:5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl && key_ok) begin
        ctrl_q.sel    <= wr_data_i[B_SEL];
        ctrl_q.ext_en <= wr_data_i[B_EXT_EN];
        ctrl_q.bypass <= wr_data_i[B_BYPASS];
      end
      // fallback overrides a same-cycle write
      if (fail_i) ctrl_q.sel <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      gate_q <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_PRE)  pre_q  <= wr_data_i[PRE_W-1:0];
      if (wr_addr_i == A_GATE) gate_q <= wr_data_i[0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[B_SEL]    = ctrl_q.sel;
        rd_data_o[B_EXT_EN] = ctrl_q.ext_en;
        rd_data_o[B_BYPASS] = ctrl_q.bypass;
      end
      A_PRE:   rd_data_o[PRE_W-1:0] = pre_q;
      A_GATE:  rd_data_o[0] = gate_q;
      default: rd_data_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign pre_n_o = pre_q;
  assign gate_o  = gate_q;

  p_key_guard_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !key_ok && !fail_i) |=> $stable(ctrl_q));
endmodule

// File: rtl/slow_tick_div.sv
module slow_tick_div #(
  parameter int unsigned FIX_DIV = 32,
  parameter int unsigned PRE_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_tick_i,
  input  logic [PRE_W-1:0] pre_n_i,
  output logic             div_tick_o
);
  localparam int unsigned FIX_W = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;

  logic             fix_tick;
  logic [PRE_W-1:0] pre_q;

  generate
    if (FIX_DIV > 1) begin : g_fixed
      logic [FIX_W-1:0] fix_q;
      assign fix_tick = int_tick_i && (fix_q == FIX_W'(FIX_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         fix_q <= '0;
        else if (fix_tick)   fix_q <= '0;
        else if (int_tick_i) fix_q <= fix_q + 1'b1;
      end
    end else begin : g_nofixed
      assign fix_tick = int_tick_i;
    end
  endgenerate

  // >= lets a lowered N take effect without a long wrap
  assign div_tick_o = fix_tick && (pre_q >= pre_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pre_q <= '0;
    else if (div_tick_o) pre_q <= '0;
    else if (fix_tick)   pre_q <= pre_q + 1'b1;
  end

  p_div_from_int_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_tick_o |-> int_tick_i);
endmodule

// File: rtl/slow_tick_watchdog.sv
module slow_tick_watchdog #(
  parameter int unsigned TIMEOUT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic int_tick_i,
  input  logic ext_tick_i,
  output logic fail_o
);
  localparam int unsigned WD_W = $clog2(TIMEOUT + 1);

  logic [WD_W-1:0] cnt_q;

  assign fail_o = armed_i && int_tick_i && !ext_tick_i &&
                  (cnt_q == WD_W'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (!armed_i || ext_tick_i || fail_o) cnt_q <= '0;
    else if (int_tick_i)                    cnt_q <= cnt_q + 1'b1;
  end

  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < WD_W'(TIMEOUT));
endmodule

// File: rtl/slow_tick_switch.sv
module slow_tick_switch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ext_i,
  input  logic force_int_i,
  input  logic int_div_tick_i,
  input  logic ext_tick_i,
  output logic tick_o,
  output logic src_ext_o
);
  logic cur_ext_q, tick_q, cur_tick;

  assign cur_tick = cur_ext_q ? ext_tick_i : int_div_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_ext_q <= 1'b0;
      tick_q    <= 1'b0;
    end else begin
      tick_q <= cur_tick;
      // commit a pending change only at a tick of the source in use
      if (force_int_i)   cur_ext_q <= 1'b0;
      else if (cur_tick) cur_ext_q <= req_ext_i;
    end
  end

  assign tick_o    = tick_q;
  assign src_ext_o = cur_ext_q;

  p_hold_between_ticks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_int_i && !cur_tick) |=> $stable(cur_ext_q));
endmodule

// File: rtl/slow_tick_sel.sv
module slow_tick_sel
  import slow_tick_pkg::*;
#(
  parameter int unsigned FIX_DIV = 32,
  parameter int unsigned PRE_W   = 5,
  parameter int unsigned TIMEOUT = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [7:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  input  logic        int_tick_i,
  input  logic        ext_tick_i,
  output logic        tick_o,
  output logic        tick_pin_o,
  output logic        src_ext_o,
  output logic        ext_osc_en_o
);
  ctrl_t            ctrl;
  logic [PRE_W-1:0] pre_n;
  logic             gate, fail, div_tick, armed;

  slow_tick_regs #(.PRE_W(PRE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .fail_i(fail), .ctrl_o(ctrl), .pre_n_o(pre_n), .gate_o(gate)
  );

  slow_tick_div #(.FIX_DIV(FIX_DIV), .PRE_W(PRE_W)) u_div (
    .clk_i, .rst_ni, .int_tick_i, .pre_n_i(pre_n), .div_tick_o(div_tick)
  );

  assign armed = src_ext_o && !ctrl.bypass;

  slow_tick_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
    .clk_i, .rst_ni, .armed_i(armed), .int_tick_i, .ext_tick_i, .fail_o(fail)
  );

  slow_tick_switch u_sw (
    .clk_i, .rst_ni, .req_ext_i(ctrl.sel), .force_int_i(fail),
    .int_div_tick_i(div_tick), .ext_tick_i, .tick_o, .src_ext_o
  );

  assign tick_pin_o   = tick_o && gate;
  assign ext_osc_en_o = ctrl.ext_en;

  p_fail_to_int_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail |=> (!src_ext_o && !ctrl.sel));

  p_bypass_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.bypass && src_ext_o && ctrl.sel) |=> src_ext_o);

  p_ext_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ext_o && ext_tick_i) |=> tick_o);
endmodule

// File: tb/slow_tick_sel_bench.sv
`timescale 1ns/1ps
module slow_tick_sel_bench;
  localparam int FIX = 32;
  localparam int TO  = 4096;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, int_t = 0, ext_t = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic tick, tick_pin, src_ext, ext_en;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slow_tick_sel u_slow_tick_sel (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .int_tick_i(int_t), .ext_tick_i(ext_t), .tick_o(tick),
    .tick_pin_o(tick_pin), .src_ext_o(src_ext), .ext_osc_en_o(ext_en)
  );

  // reference model built from the requirements
  logic m_sel, m_ext_en, m_byp, m_gate, m_cur, m_tick;
  logic [4:0] m_n, m_pre;
  int m_fix, m_wd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_ext_en = 0; m_byp = 0; m_gate = 0; m_cur = 0; m_tick = 0;
      m_n = 0; m_pre = 0; m_fix = 0; m_wd = 0;
    end else begin : mdl
      logic fix_t, div_t, armed, fl, cur_t;
      fix_t = int_t && (m_fix == FIX - 1);
      div_t = fix_t && (m_pre >= m_n);
      if (int_t) m_fix = fix_t ? 0 : m_fix + 1;
      if (fix_t) m_pre = div_t ? 5'd0 : m_pre + 5'd1;
      armed = m_cur && !m_byp;
      fl = armed && int_t && !ext_t && (m_wd == TO - 1);
      if (!armed || ext_t || fl) m_wd = 0; else if (int_t) m_wd = m_wd + 1;
      cur_t = m_cur ? ext_t : div_t;
      m_tick = cur_t;
      if (fl) m_cur = 0; else if (cur_t) m_cur = m_sel;
      if (wr_en && wr_addr == 8'h00 && wr_data[31:16] == 16'h16AA) begin
        m_sel = wr_data[0]; m_ext_en = wr_data[4]; m_byp = wr_data[15];
      end
      if (wr_en && wr_addr == 8'h08) m_n = wr_data[4:0];
      if (wr_en && wr_addr == 8'h60) m_gate = wr_data[0];
      if (fl) m_sel = 0;
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00:   return {16'h0, m_byp, 10'h0, m_ext_en, 3'h0, m_sel};
      8'h08:   return {27'h0, m_n};
      8'h60:   return {31'h0, m_gate};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      if (n_fail < 20) $display("FAIL %s act %0h exp %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk(tick == m_tick, "R3/R4/R5 tick_o", tick, m_tick);
    chk(tick_pin == (m_tick & m_gate), "R8 tick_pin_o", tick_pin, m_tick & m_gate);
    chk(src_ext == m_cur, "R5/R6/R7 src_ext_o", src_ext, m_cur);
    chk(ext_en == m_ext_en, "R2 ext_osc_en_o", ext_en, m_ext_en);
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] lit, bit use_lit, string tag);
    logic [31:0] e;
    @(negedge clk); #1;
    rd_addr = a;
    @(negedge clk);
    e = use_lit ? lit : exp_rd(a);
    chk(rd_data == e, tag, rd_data, e);
  endtask

  // imode/emode: 0 none, 1 every cycle, 2 random
  task automatic run(int n, int imode, int emode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      int_t = (imode == 1) || (imode == 2 && ($urandom % 3 == 0));
      ext_t = (emode == 1) || (emode == 2 && ($urandom % 9 == 0));
    end
    @(negedge clk); #1;
    int_t = 0; ext_t = 0;
  endtask

  int wdog = 0;
  always @(posedge clk) begin
    wdog++;
    if (wdog == 150000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired act 0 exp 1");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R9 reset state
    @(negedge clk);
    chk(tick == 0 && tick_pin == 0 && src_ext == 0, "R9 outputs", {tick, tick_pin, src_ext}, 0);
    rd(8'h00, 32'h0, 1, "R9 ctrl");
    rd(8'h08, 32'h0, 1, "R9 pre");
    rd(8'h60, 32'h0, 1, "R9 gate");
    // R1 key guard
    wr(8'h00, 32'h1234_8011);
    rd(8'h00, 32'h0, 1, "R1 bad key ignored");
    wr(8'h00, 32'h16AB_0001);
    rd(8'h00, 32'h0, 1, "R1 near key ignored");
    // R2 field layout with key
    wr(8'h00, 32'h16AA_FFFF);
    rd(8'h00, 32'h0000_8011, 1, "R2 ctrl read");
    chk(ext_en == 1, "R2 ext_osc_en_o", ext_en, 1);
    wr(8'h00, 32'h16AA_0010);
    rd(8'h00, 32'h0000_0010, 1, "R2 ctrl read");
    // R8 gate, R3 prescaler readback
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, 32'h1, 1, "R8 gate read");
    wr(8'h08, 32'hFFFF_FFE3);
    rd(8'h08, 32'h3, 1, "R3 pre read");
    // R3 period: N=3, internal every cycle, 128-cycle period
    run(200, 1, 0);
    cnt = 0;
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk); #1; int_t = 1; ext_t = 0;
      if (tick) cnt++;
    end
    chk(cnt == 16, "R3 tick count", cnt, 16);
    // R5 and R6: switch to external, then external dies
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h16AA_0011);
    run(40, 1, 0);
    chk(src_ext == 1, "R5 switched to external", src_ext, 1);
    run(200, 1, 2);   // R4 external ticks followed
    run(TO + 20, 1, 0);
    chk(src_ext == 0, "R6 fallback to internal", src_ext, 0);
    rd(8'h00, 32'h0000_0010, 1, "R6 sel cleared");
    // R7 bypass
    wr(8'h00, 32'h16AA_8011);
    run(40, 1, 0);
    run(TO + 900, 1, 0);
    chk(src_ext == 1, "R7 bypass holds external", src_ext, 1);
    rd(8'h00, 32'h0000_8011, 1, "R7 sel kept");
    // R5 switch back waits for an external tick
    wr(8'h00, 32'h16AA_0010);
    run(30, 1, 0);
    chk(src_ext == 1, "R5 old source held", src_ext, 1);
    run(30, 1, 1);
    chk(src_ext == 0, "R5 switched to internal", src_ext, 0);
    // random traffic
    for (int k = 0; k < 60; k++) begin
      int r;
      r = $urandom % 6;
      case (r)
        0: wr(8'h00, {16'h16AA, 16'($urandom)});
        1: wr(8'h00, $urandom);
        2: wr(8'h08, $urandom);
        3: wr(8'h60, $urandom);
        4: rd(8'h00, 0, 0, "R1/R2 ctrl read");
        default: rd(8'($urandom % 4 * 8), 0, 0, "R3/R8 reg read");
      endcase
      run(40 + $urandom % 120, 2, 2);
    end
    rd(8'h44, 32'h0, 1, "R2 unmapped read zero");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule